// File: doc/BRIEF.md
# Software-Driven Single-Transfer Bus Master

This block lets software place exactly one transfer on a PCI-style parallel bus without a DMA engine. Software programs a target address, a write word and a control word that carries the bus command and byte enables. It then sets a start bit. The master requests the bus, waits for a grant and presents one address/data phase. It then waits for the target to complete, retry or abort. On a read it keeps the returned word in a read-only register.

Completion raises a sticky done flag. The flag shows in the control word and in a status word, and it stays set until software writes a separate clear location. The same write also clears the abort error flag. When the command is a type 0 configuration access, the five-bit device number in address bits 15:11 is turned into a one-hot select on bus address bits 31:11.

Register offsets (word index on `reg_addr`): 0 address, 1 write data, 2 read data, 3 control, 4 status, 5 clear. Control layout: bits 3:0 command, bits 7:4 byte enables, bit 9 start, bit 10 done, all other bits read 0. Status layout: bit 0 done, bit 1 error. Command codes: 2 I/O read, 3 I/O write, 6 memory read, 7 memory write, 10 configuration read, 11 configuration write. Bit 0 of the command set to 1 means a write.

Top module: `sdp_master`

## Requirements
- R1: The address register (offset 0) changes only on a write with all four byte enables set; a write with any byte enable clear leaves it unchanged.
- R2: The write-data register (offset 1) updates exactly those bytes whose byte enable is set.
- R3: The read-data register (offset 2) ignores register writes and changes only when a read command completes with ready; an aborted read leaves it unchanged.
- R4: Writing 1 to control bit 9 starts exactly one transfer. `bus_valid` rises once, carrying the programmed command, byte enables and write word. For any access other than a type 0 configuration access, the address passes unchanged.
- R5: Control bit 10 reads 1 after a transfer has finished, and control bits 31:11 and bit 8 always read 0.
- R6: Status bit 0 mirrors done. Done stays 1 until any write to offset 5, which also clears the error flag.
- R7: For a configuration command (10 or 11) whose address bits 1:0 are 00, bus address bits 10:0 equal the programmed bits 10:0. Bus address bit 11+n is 1 for device number n (programmed bits 15:11), and the other bits of 31:11 are 0. With bits 1:0 not 00, the address passes unchanged.
- R8: After reset every register reads 0 and `bus_req` is low.
- R9: A device number above 20 produces no select bit: bus address bits 31:11 are all 0.
- R10: The start bit reads 0 once the transfer has been launched. A start written while a transfer is pending or in flight causes no further transfer.
- R11: A target retry makes the master drop `bus_valid`, request the bus again and re-issue the identical transfer until it completes.
- R12: A target abort ends the transfer, sets done and sets status bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_be | input | 4 | Register write byte enables |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| bus_req | output | 1 | Bus request, high from launch to completion |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | Address/data phase active |
| bus_addr | output | 32 | Bus address (after configuration expansion) |
| bus_cmd | output | 4 | Bus command |
| bus_be | output | 4 | Bus byte enables |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Read data from target |
| bus_ready | input | 1 | Target completes the data phase |
| bus_retry | input | 1 | Target asks for the transfer to be reissued |
| bus_abort | input | 1 | Transfer aborted |

## Verification
The bench drives the boundary device numbers 3, 20 and 25. It also uses a configuration address whose low bits are not 00. A decoder that is off by one or does not saturate would light the wrong select bit, or a bit for device 25. The bench sends a start while the grant is held off. A master that latched that second start would issue an extra transfer, which the scoreboard reports as unexpected. Retries are counted against repeated scoreboard entries, so an address that drifts between attempts or a retry taken as completion shows up. An abort on a read must leave the previous read word in place and raise the error flag. Done must survive idle cycles and fall only on the clear write.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
   localparam int REG_AW = 3;
   localparam int CMD_W  = 4;

   localparam logic [REG_AW-1:0] OFS_ADDR  = 3'd0;
   localparam logic [REG_AW-1:0] OFS_WDATA = 3'd1;
   localparam logic [REG_AW-1:0] OFS_RDATA = 3'd2;
   localparam logic [REG_AW-1:0] OFS_CTRL  = 3'd3;
   localparam logic [REG_AW-1:0] OFS_STAT  = 3'd4;
   localparam logic [REG_AW-1:0] OFS_CLR   = 3'd5;

   localparam int CTL_BE_LSB = 4;
   localparam int CTL_START  = 9;
   localparam int CTL_DONE   = 10;

   typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_XFER} mst_state_t;

   function automatic logic is_cfg0(input logic [CMD_W-1:0] cmd, input logic [1:0] alo);
      return (cmd[3:1] == 3'b101) && (alo == 2'b00);
   endfunction
endpackage

// File: rtl/sdp_addr_map.sv
module sdp_addr_map #(
   parameter int AW      = 32,
   parameter int DEV_LSB = 11,
   parameter int DEV_W   = 5
) (
   input  logic [AW-1:0]              addr_in,
   input  logic [sdp_pkg::CMD_W-1:0]  cmd,
   output logic [AW-1:0]              addr_out
);
   localparam int SEL_W = AW - DEV_LSB;

   logic [DEV_W-1:0] dev;
   logic [SEL_W-1:0] sel;

   assign dev = addr_in[DEV_LSB +: DEV_W];

   for (genvar i = 0; i < SEL_W; i++) begin : g_sel
      assign sel[i] = (dev == DEV_W'(i));
   end

   assign addr_out = sdp_pkg::is_cfg0(cmd, addr_in[1:0]) ?
                     {sel, addr_in[DEV_LSB-1:0]} : addr_in;
endmodule

// File: rtl/sdp_regs.sv
module sdp_regs #(
   parameter int DW = 32,
   parameter int AW = 32
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        reg_we,
   input  logic [sdp_pkg::REG_AW-1:0]  reg_addr,
   input  logic [DW/8-1:0]             reg_be,
   input  logic [DW-1:0]               reg_wdata,
   output logic [DW-1:0]               reg_rdata,
   input  logic                        busy,
   input  logic                        launch,
   input  logic                        finish,
   input  logic                        fin_abort,
   input  logic                        cap_en,
   input  logic [DW-1:0]               bus_rdata,
   output logic [AW-1:0]               addr_q,
   output logic [DW-1:0]               wdata_q,
   output logic [sdp_pkg::CMD_W-1:0]   cmd_q,
   output logic [DW/8-1:0]             be_q,
   output logic                        start_q,
   output logic                        done_q,
   output logic                        err_q
);
   import sdp_pkg::*;
   localparam int BE_W = DW / 8;

   logic [DW-1:0] rdata_q;
   logic          wr_addr, wr_wdata, wr_ctrl, wr_clr;

   assign wr_addr  = reg_we && (reg_addr == OFS_ADDR);
   assign wr_wdata = reg_we && (reg_addr == OFS_WDATA);
   assign wr_ctrl  = reg_we && (reg_addr == OFS_CTRL);
   assign wr_clr   = reg_we && (reg_addr == OFS_CLR);

   for (genvar b = 0; b < BE_W; b++) begin : g_lane
      always_ff @(posedge clk) begin
         if (rst)                        wdata_q[8*b +: 8] <= '0;
         else if (wr_wdata && reg_be[b]) wdata_q[8*b +: 8] <= reg_wdata[8*b +: 8];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q  <= '0;
         cmd_q   <= '0;
         be_q    <= '0;
         start_q <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         if (wr_addr && (&reg_be)) addr_q <= reg_wdata[AW-1:0];
         if (wr_ctrl && reg_be[0]) begin
            cmd_q <= reg_wdata[CMD_W-1:0];
            be_q  <= reg_wdata[CTL_BE_LSB +: BE_W];
         end
         if (launch)
            start_q <= 1'b0;
         else if (wr_ctrl && reg_be[1] && reg_wdata[CTL_START] && !busy && !start_q)
            start_q <= 1'b1;
         if (finish) begin
            done_q <= 1'b1;
            if (fin_abort) err_q <= 1'b1;
         end else if (wr_clr) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
         end
         if (cap_en) rdata_q <= bus_rdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         OFS_ADDR:  reg_rdata[AW-1:0] = addr_q;
         OFS_WDATA: reg_rdata = wdata_q;
         OFS_RDATA: reg_rdata = rdata_q;
         OFS_CTRL: begin
            reg_rdata[CMD_W-1:0]            = cmd_q;
            reg_rdata[CTL_BE_LSB +: BE_W]   = be_q;
            reg_rdata[CTL_START]            = start_q;
            reg_rdata[CTL_DONE]             = done_q;
         end
         OFS_STAT: reg_rdata[1:0] = {err_q, done_q};
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/sdp_fsm.sv
module sdp_fsm #(
   parameter int DW = 32,
   parameter int AW = 32
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       start_q,
   input  logic [AW-1:0]              map_addr,
   input  logic [sdp_pkg::CMD_W-1:0]  cmd_q,
   input  logic [DW/8-1:0]            be_q,
   input  logic [DW-1:0]              wdata_q,
   input  logic                       bus_gnt,
   input  logic                       bus_ready,
   input  logic                       bus_retry,
   input  logic                       bus_abort,
   output logic                       launch,
   output logic                       busy,
   output logic                       finish,
   output logic                       fin_abort,
   output logic                       cap_en,
   output logic                       bus_req,
   output logic                       bus_valid,
   output logic [AW-1:0]              bus_addr,
   output logic [sdp_pkg::CMD_W-1:0]  bus_cmd,
   output logic [DW/8-1:0]            bus_be,
   output logic [DW-1:0]              bus_wdata
);
   import sdp_pkg::*;

   mst_state_t state;

   assign launch    = (state == ST_IDLE) && start_q;
   assign busy      = (state != ST_IDLE);
   assign bus_req   = busy;
   assign bus_valid = (state == ST_XFER);
   assign finish    = bus_valid && (bus_ready || bus_abort);
   assign fin_abort = bus_valid && bus_abort;
   assign cap_en    = bus_valid && bus_ready && !bus_abort && !bus_cmd[0];

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_IDLE;
         bus_addr  <= '0;
         bus_cmd   <= '0;
         bus_be    <= '0;
         bus_wdata <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (start_q) begin
               state     <= ST_REQ;
               bus_addr  <= map_addr;
               bus_cmd   <= cmd_q;
               bus_be    <= be_q;
               bus_wdata <= wdata_q;
            end
            ST_REQ:  if (bus_gnt) state <= ST_XFER;
            ST_XFER: begin
               if (bus_abort || bus_ready) state <= ST_IDLE;
               else if (bus_retry)         state <= ST_REQ;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sdp_master.sv
module sdp_master #(
   parameter int DW      = 32,
   parameter int AW      = 32,
   parameter int DEV_LSB = 11,
   parameter int DEV_W   = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          reg_we,
   input  logic [2:0]    reg_addr,
   input  logic [3:0]    reg_be,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          bus_req,
   input  logic          bus_gnt,
   output logic          bus_valid,
   output logic [31:0]   bus_addr,
   output logic [3:0]    bus_cmd,
   output logic [3:0]    bus_be,
   output logic [31:0]   bus_wdata,
   input  logic [31:0]   bus_rdata,
   input  logic          bus_ready,
   input  logic          bus_retry,
   input  logic          bus_abort
);
   localparam int BE_W  = DW / 8;
   localparam int SEL_W = AW - DEV_LSB;

   if (DW != 32 || AW != 32)
      $error("sdp_master: ports are fixed at 32 bits");
   if (DEV_LSB + DEV_W > AW || DEV_LSB < 2)
      $error("sdp_master: device field out of range");
   if (SEL_W > (1 << DEV_W))
      $error("sdp_master: select field wider than device decode");
   if (sdp_pkg::CTL_BE_LSB + BE_W > sdp_pkg::CTL_START)
      $error("sdp_master: byte-enable field overlaps start bit");

   logic [AW-1:0]              addr_q, map_addr;
   logic [DW-1:0]              wdata_q;
   logic [sdp_pkg::CMD_W-1:0]  cmd_q;
   logic [BE_W-1:0]            be_q;
   logic start_q, done_q, err_q;
   logic launch, busy, finish, fin_abort, cap_en;

   sdp_regs #(.DW(DW), .AW(AW)) u_regs (
      .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .launch(launch),
      .finish(finish), .fin_abort(fin_abort), .cap_en(cap_en), .bus_rdata(bus_rdata),
      .addr_q(addr_q), .wdata_q(wdata_q), .cmd_q(cmd_q), .be_q(be_q),
      .start_q(start_q), .done_q(done_q), .err_q(err_q)
   );

   sdp_addr_map #(.AW(AW), .DEV_LSB(DEV_LSB), .DEV_W(DEV_W)) u_map (
      .addr_in(addr_q), .cmd(cmd_q), .addr_out(map_addr)
   );

   sdp_fsm #(.DW(DW), .AW(AW)) u_fsm (
      .clk(clk), .rst(rst), .start_q(start_q), .map_addr(map_addr), .cmd_q(cmd_q),
      .be_q(be_q), .wdata_q(wdata_q), .bus_gnt(bus_gnt), .bus_ready(bus_ready),
      .bus_retry(bus_retry), .bus_abort(bus_abort), .launch(launch), .busy(busy),
      .finish(finish), .fin_abort(fin_abort), .cap_en(cap_en), .bus_req(bus_req),
      .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_cmd(bus_cmd), .bus_be(bus_be),
      .bus_wdata(bus_wdata)
   );
endmodule

// File: rtl/sdp_master_chk.sv
module sdp_master_chk #(
   parameter int AW      = 32,
   parameter int DEV_LSB = 11
) (
   input logic          clk,
   input logic          rst,
   input logic          reg_we,
   input logic [2:0]    reg_addr,
   input logic          bus_req,
   input logic          bus_valid,
   input logic [AW-1:0] bus_addr,
   input logic [3:0]    bus_cmd,
   input logic          bus_ready,
   input logic          bus_retry,
   input logic          bus_abort,
   input logic          done_q,
   input logic          err_q
);
   // R8
   reset_idle_chk: assert property (@(posedge clk) rst |=> !bus_req && !done_q);

   // R4
   phase_stable_chk: assert property (@(posedge clk) disable iff (rst)
      bus_valid && $past(bus_valid) |-> $stable(bus_addr) && $stable(bus_cmd));

   // R7
   cfg_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      bus_valid && bus_cmd[3:1] == 3'b101 && bus_addr[1:0] == 2'b00
      |-> $onehot0(bus_addr[AW-1:DEV_LSB]));

   // R6
   done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      done_q && !(reg_we && reg_addr == sdp_pkg::OFS_CLR) |=> done_q);

   // R11
   retry_rearb_chk: assert property (@(posedge clk) disable iff (rst)
      bus_valid && bus_retry && !bus_ready && !bus_abort |=> bus_req && !bus_valid);

   // R12
   abort_flag_chk: assert property (@(posedge clk) disable iff (rst)
      bus_valid && bus_abort |=> done_q && err_q);
endmodule

bind sdp_master sdp_master_chk #(.AW(AW), .DEV_LSB(DEV_LSB)) u_chk (
   .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .bus_req(bus_req),
   .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_cmd(bus_cmd), .bus_ready(bus_ready),
   .bus_retry(bus_retry), .bus_abort(bus_abort), .done_q(done_q), .err_q(err_q)
);

// File: tb/sim_sdp_master.sv
`timescale 1ns/1ps
module sim_sdp_master;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [3:0]  reg_be = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        bus_req, bus_valid;
   logic        bus_gnt = 1'b0;
   logic [31:0] bus_addr, bus_wdata;
   logic [3:0]  bus_cmd, bus_be;
   logic [31:0] bus_rdata = '0;
   logic        bus_ready = 1'b0, bus_retry = 1'b0, bus_abort = 1'b0;

   always #2.5 clk = ~clk;

   sdp_master u0 (.*);

   typedef struct packed {
      logic [31:0] a;
      logic [3:0]  c;
      logic [3:0]  b;
      logic [31:0] d;
   } txn_t;

   txn_t exp_q[$];
   int   n_chk = 0;
   int   n_fail = 0;
   bit   ended = 0;

   int   mode = 0;          // 0 ready, 2 abort
   int   retries_left = 0;
   bit   gnt_block = 0;
   int   vcnt = 0;
   bit   prev_valid = 0;

   // target model
   always @(negedge clk) begin
      if (rst) begin
         bus_gnt = 0; bus_ready = 0; bus_retry = 0; bus_abort = 0; vcnt = 0;
      end else begin
         bus_ready = 0; bus_retry = 0; bus_abort = 0;
         bus_gnt = bus_req && !gnt_block;
         if (bus_valid) begin
            vcnt++;
            if (vcnt == 2) begin
               vcnt = 0;
               if (mode == 2) bus_abort = 1;
               else if (retries_left > 0) begin bus_retry = 1; retries_left--; end
               else bus_ready = 1;
            end
         end else vcnt = 0;
      end
   end

   // monitor: compare each new bus phase with the scoreboard
   always @(negedge clk) begin
      if (!rst && bus_valid && !prev_valid) begin
         txn_t got, exp;
         got = '{bus_addr, bus_cmd, bus_be, bus_wdata};
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R4/R10 unexpected transfer act=%h exp=none", got);
         end else begin
            exp = exp_q.pop_front();
            if (got !== exp) begin
               n_fail++;
               $display("FAIL R4/R7/R9/R11 transfer act=%h exp=%h", got, exp);
            end
         end
      end
      prev_valid = bus_valid;
   end

   function automatic logic [31:0] exp_addr(input logic [3:0] c, input logic [31:0] a);
      logic [31:0] r;
      int dev;
      if (c[3:1] != 3'b101 || a[1:0] != 2'b00) return a;
      r = {21'b0, a[10:0]};
      dev = int'(a[15:11]);
      if (dev <= 20) r[11 + dev] = 1'b1;
      return r;
   endfunction

   task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      reg_we = 1; reg_addr = a; reg_wdata = d; reg_be = be;
      @(negedge clk);
      reg_we = 0; reg_be = 0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a;
      #1;
      n_chk++;
      if (reg_rdata !== exp) begin
         n_fail++;
         $display("FAIL %s offset %0d act=%h exp=%h", tag, a, reg_rdata, exp);
      end
   endtask

   task automatic go(input logic [3:0] c, input logic [3:0] be, input logic [31:0] a,
                     input logic [31:0] d, input int copies);
      wr(3'd0, a, 4'hF);
      wr(3'd1, d, 4'hF);
      for (int i = 0; i < copies; i++) exp_q.push_back('{exp_addr(c, a), c, be, d});
      wr(3'd3, (32'h1 << 9) | (32'(be) << 4) | 32'(c), 4'hF);
   endtask

   task automatic wait_done(input string tag);
      bit seen = 0;
      for (int i = 0; i < 200 && !seen; i++) begin
         @(negedge clk);
         reg_addr = 3'd4;
         #1;
         if (reg_rdata[0]) seen = 1;
      end
      n_chk++;
      if (!seen) begin
         n_fail++;
         $display("FAIL %s done never set act=0 exp=1", tag);
      end
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 0;

      // R8 reset values
      for (int o = 0; o < 6; o++) rd(3'(o), 32'h0, "R8 reset");
      n_chk++;
      if (bus_req !== 1'b0) begin n_fail++; $display("FAIL R8 bus_req act=%b exp=0", bus_req); end

      // R1 address register takes full-word writes only
      wr(3'd0, 32'h1234_5678, 4'hF);
      wr(3'd0, 32'hFFFF_FFFF, 4'h3);
      rd(3'd0, 32'h1234_5678, "R1 partial write");
      wr(3'd0, 32'h0, 4'hE);
      rd(3'd0, 32'h1234_5678, "R1 three-byte write");

      // R2 byte lanes of write data
      wr(3'd1, 32'hAABB_CCDD, 4'hF);
      wr(3'd1, 32'h1122_3344, 4'h5);
      rd(3'd1, 32'hAA22_CC44, "R2 byte lanes");

      // R4 memory write, R5 control view, R6 sticky done
      go(4'h7, 4'hF, 32'h8000_0010, 32'hDEAD_BEEF, 1);
      wait_done("R4 mem write");
      rd(3'd3, 32'h0000_04F7, "R5 control after done");
      rd(3'd4, 32'h1, "R6 status done");
      repeat (10) @(negedge clk);
      rd(3'd4, 32'h1, "R6 done sticky");
      wr(3'd5, 32'h0, 4'h1);
      rd(3'd4, 32'h0, "R6 clear");
      rd(3'd3, 32'h0000_00F7, "R5 done cleared");

      // R3 memory read captures data, write to read-data ignored
      bus_rdata = 32'hCAFE_F00D;
      go(4'h6, 4'h3, 32'h0000_2000, 32'h0, 1);
      wait_done("R3 mem read");
      rd(3'd2, 32'hCAFE_F00D, "R3 read capture");
      wr(3'd2, 32'h0, 4'hF);
      rd(3'd2, 32'hCAFE_F00D, "R3 read-only");
      wr(3'd5, 32'h0, 4'hF);

      // R4 I/O write with one byte enabled
      go(4'h3, 4'h1, 32'h0000_03F8, 32'h0000_0055, 1);
      wait_done("R4 io write");
      wr(3'd5, 32'h0, 4'hF);

      // R7 configuration expansion, R9 out-of-range device
      go(4'hA, 4'hF, 32'hABCD_1904, 32'h0, 1);
      wait_done("R7 cfg dev 3");
      wr(3'd5, 32'h0, 4'hF);
      go(4'hB, 4'hF, 32'h0000_A008, 32'h0BAD_0001, 1);
      wait_done("R7 cfg dev 20");
      wr(3'd5, 32'h0, 4'hF);
      go(4'hA, 4'hF, 32'h0000_C80C, 32'h0, 1);
      wait_done("R9 cfg dev 25");
      wr(3'd5, 32'h0, 4'hF);
      go(4'hA, 4'hF, 32'h0000_1901, 32'h0, 1);
      wait_done("R7 cfg not type 0");
      wr(3'd5, 32'h0, 4'hF);

      // R11 two retries then completion
      retries_left = 2;
      go(4'h7, 4'hC, 32'h0000_0100, 32'h1357_9BDF, 3);
      wait_done("R11 retry");
      rd(3'd4, 32'h1, "R11 no error after retry");
      wr(3'd5, 32'h0, 4'hF);

      // R12 abort on a read
      mode = 2;
      bus_rdata = 32'h9999_9999;
      go(4'h6, 4'hF, 32'h0000_0200, 32'h0, 1);
      wait_done("R12 abort");
      rd(3'd4, 32'h3, "R12 done and error");
      rd(3'd2, 32'hCAFE_F00D, "R3 abort keeps read data");
      wr(3'd5, 32'h0, 4'hF);
      rd(3'd4, 32'h0, "R6 clear drops error");
      mode = 0;

      // R10 self-clearing start, start while busy ignored
      gnt_block = 1;
      go(4'h7, 4'hF, 32'h0000_0040, 32'h0000_0001, 1);
      repeat (3) @(negedge clk);
      rd(3'd3, 32'h0000_00F7, "R10 start self-clears");
      wr(3'd3, 32'h0000_02F7, 4'hF);
      gnt_block = 0;
      wait_done("R10 blocked transfer");
      wr(3'd5, 32'h0, 4'hF);
      repeat (30) @(negedge clk);
      rd(3'd4, 32'h0, "R10 no second transfer");
      n_chk++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R4 pending scoreboard act=%0d exp=0", exp_q.size());
      end

      summary();
   end
endmodule